// File: doc/BRIEF.md
# Dual-Mode Biphase Line Encoder

This block turns a serial stream of data bits into a two-level line signal, using one of two biphase codes: FM0 or Manchester. Each bit occupies two cycles of a clock that runs at twice the bit rate. The first cycle carries the first half-symbol (A) and the second cycle carries the second half-symbol (B). An internal half-phase flag tracks which half is on the line.

A single select input chooses the code. Both codes share one multiplexer, one XNOR and one history flop. For FM0, the history flop keeps only the level of the previous bit's second half. The block asks for data with a strobe that is high during each second half. The bit present at the end of that cycle is taken in, and its A half-symbol appears on the line in the next cycle.

Top module: `biphase_line_enc`

## Requirements
- R1: After reset, `line_out` is 0 and `bit_req` is 0. The first bit period behaves as an idle FM0 data 1, so the line stays low for both of its halves.
- R2: `bit_req` is high in every second-half cycle and low in every first-half cycle, so it alternates on every clock after reset.
- R3: `bit_in` and `fm0_sel` are sampled on the rising edge that ends a cycle with `bit_req` high. The A half of that bit is on `line_out` in the next cycle, and the B half is on it in the cycle after that. `line_out` is a flop output.
- R4: In FM0 mode (`fm0_sel` = 1), the A half of every bit is the inverse of the B half of the bit before it.
- R5: In FM0 mode, a data 0 gives a B half that differs from its A half.
- R6: In FM0 mode, a data 1 gives a B half equal to its A half.
- R7: In Manchester mode (`fm0_sel` = 0), the A half is the complement of the data bit and the B half is the data bit itself, so a 1 goes low then high.
- R8: Changes of `fm0_sel` or `bit_in` during a bit period have no effect on the line until they are sampled at the next bit boundary.
- R9: When the code switches from Manchester to FM0 at a boundary, the first FM0 A half is the inverse of the last Manchester B half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Next data bit, sampled at the end of a `bit_req` cycle |
| fm0_sel | input | 1 | Code select: 1 = FM0, 0 = Manchester, sampled with `bit_in` |
| line_out | output | 1 | Registered encoded line level |
| bit_req | output | 1 | High during the second half of each bit period |

## Verification
The assertions assume that the data and code select are meaningful only at the edge that closes a `bit_req` cycle. The checker captures both inputs at that edge and judges each half-symbol against the captured values, not against the live inputs. The stimulus deliberately flips the select input during first halves and sets the intended value only in the strobe cycle. This keeps the inputs within that assumption while still testing that mid-bit changes are ignored. Data patterns cover constant 0, constant 1, alternating bits, pseudo-random bits and frequent switches between the two codes.

// File: rtl/biphase_enc_pkg.sv
package biphase_enc_pkg;

    typedef struct packed {
        logic half;   // 0 = first half (A), 1 = second half (B)
        logic data;   // bit being sent
        logic fm0;    // code of the bit being sent
        logic line;   // registered line level
        logic hist;   // B level of the previous bit
    } enc_state_t;

    // Reset is the A half of an idle FM0 data 1 whose predecessor ended high.
    localparam enc_state_t ENC_RESET = '{half: 1'b0, data: 1'b1, fm0: 1'b1,
                                         line: 1'b0, hist: 1'b1};

endpackage

// File: rtl/biphase_phase_ctl.sv
module biphase_phase_ctl (
    input  logic half_q,
    output logic half_d,
    output logic boundary,
    output logic req
);
    always_comb begin
        half_d   = ~half_q;
        boundary = half_q;
        req      = half_q;
    end
endmodule

// File: rtl/biphase_symbol.sv
module biphase_symbol (
    input  logic boundary,   // 1: produce A of a new bit, 0: produce B
    input  logic fm0,
    input  logic data,
    input  logic hist,
    input  logic line_now,
    output logic sym
);
    logic shared_sel;
    logic a_lvl;
    logic b_lvl;

    always_comb begin
        // One mux serves both codes; the inversion follows it.
        shared_sel = fm0 ? hist : data;
        a_lvl      = ~shared_sel;
        // XNOR: FM0 keeps A for a 1 and flips for a 0; Manchester always flips.
        b_lvl      = ~(line_now ^ (fm0 & data));
        sym        = boundary ? a_lvl : b_lvl;
    end
endmodule

// File: rtl/biphase_line_enc.sv
module biphase_line_enc
    import biphase_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic fm0_sel,
    output logic line_out,
    output logic bit_req
);
    enc_state_t st_q;
    enc_state_t st_d;

    logic half_nx;
    logic at_boundary;
    logic sym_lvl;
    logic src_data;
    logic src_fm0;

    biphase_phase_ctl u_phase (
        .half_q   (st_q.half),
        .half_d   (half_nx),
        .boundary (at_boundary),
        .req      (bit_req)
    );

    always_comb begin
        src_data = at_boundary ? bit_in  : st_q.data;
        src_fm0  = at_boundary ? fm0_sel : st_q.fm0;
    end

    biphase_symbol u_sym (
        .boundary (at_boundary),
        .fm0      (src_fm0),
        .data     (src_data),
        .hist     (st_q.hist),
        .line_now (st_q.line),
        .sym      (sym_lvl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.half = half_nx;
        st_d.line = sym_lvl;
        if (at_boundary) begin
            st_d.data = bit_in;
            st_d.fm0  = fm0_sel;
        end else begin
            // B level kept in every code, so a switch into FM0 stays continuous.
            st_d.hist = sym_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ENC_RESET;
        else        st_q <= st_d;
    end

    assign line_out = st_q.line;

endmodule

// File: rtl/biphase_line_enc_chk.sv
module biphase_line_enc_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_in,
    input logic fm0_sel,
    input logic line_out,
    input logic bit_req
);
    logic cap_fm0;
    logic cap_dat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_fm0 <= 1'b1;
            cap_dat <= 1'b1;
        end else if (bit_req) begin
            cap_fm0 <= fm0_sel;
            cap_dat <= bit_in;
        end
    end

    assert_req_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |=> !bit_req);
    assert_req_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_req |=> bit_req);
    assert_fm0_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && fm0_sel) |=> (line_out != $past(line_out)));
    assert_fm0_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_req && cap_fm0 && !cap_dat) |=> (line_out != $past(line_out)));
    assert_fm0_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_req && cap_fm0 && cap_dat) |=> $stable(line_out));
    assert_man_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_req && !cap_fm0) |-> (line_out == !cap_dat));
    assert_man_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && !cap_fm0) |-> (line_out == cap_dat));
endmodule

bind biphase_line_enc biphase_line_enc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (bit_in),
    .fm0_sel  (fm0_sel),
    .line_out (line_out),
    .bit_req  (bit_req)
);

// File: tb/biphase_line_enc_test.sv
module biphase_line_enc_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_BITS   = 420;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic fm0_sel = 1'b1;
    logic line_out;
    logic bit_req;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    biphase_line_enc uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .fm0_sel(fm0_sel),
        .line_out(line_out), .bit_req(bit_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: expected level per cycle from the requirements.
    bit m_half, m_line, m_d, m_fm0, m_prev_b, m_switched, m_decoy, m_decoy_bit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_half = 0; m_line = 0; m_d = 1; m_fm0 = 1; m_prev_b = 1;
            m_switched = 0; m_decoy_bit = 0;
        end else if (m_half) begin
            m_switched  = fm0_sel && !m_fm0;
            m_decoy_bit = m_decoy;
            m_d   = bit_in;
            m_fm0 = fm0_sel;
            m_line = m_fm0 ? !m_prev_b : !m_d;
            m_half = 0;
        end else begin
            if (m_fm0) m_line = m_d ? m_line : !m_line;
            else       m_line = m_d;
            m_prev_b = m_line;
            m_half = 1;
        end
    end

    task automatic check(input bit got, input bit exp, input string req, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic string line_tag();
        if (m_decoy_bit) return "R8";
        if (m_switched && !m_half) return "R9";
        if (!m_fm0) return "R7";
        if (!m_half) return "R4";
        return m_d ? "R6" : "R5";
    endfunction

    int lfsr = 32'h1ACE5;
    function automatic bit rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hA3000000 : 0);
        return lfsr[0];
    endfunction

    initial begin
        int bits_sent = 0;
        bit want_fm0 = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen before the first active edge
        check(line_out, 1'b0, "R1", "line after reset");
        check(bit_req, 1'b0, "R1", "bit_req after reset");
        @(negedge clk);
        check(line_out, 1'b0, "R1", "idle B half");
        check(bit_req, 1'b1, "R2", "strobe in second half");
        while (bits_sent < NUM_BITS) begin
            if (bit_req) begin
                // R3: present the next bit during the strobe cycle
                if (bits_sent < 32)       begin want_fm0 = 1; bit_in = 1'b0; end
                else if (bits_sent < 64)  begin want_fm0 = 1; bit_in = 1'b1; end
                else if (bits_sent < 96)  begin want_fm0 = 1; bit_in = bits_sent[0]; end
                else if (bits_sent < 128) begin want_fm0 = 0; bit_in = bits_sent[0]; end
                else if (bits_sent < 192) begin want_fm0 = 0; bit_in = rnd(); end
                else begin
                    if (bits_sent % 3 == 0) want_fm0 = rnd();
                    bit_in = rnd();
                end
                fm0_sel = want_fm0;
                m_decoy = 0;
                bits_sent++;
            end else if (bits_sent >= 160) begin
                // R8: disturb the inputs mid-bit; they must be ignored
                fm0_sel = !want_fm0;
                bit_in  = !bit_in;
                m_decoy = 1;
            end
            @(negedge clk);
            check(bit_req, m_half, "R2", "strobe phase");
            check(line_out, m_line, line_tag(), "line level");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule